// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of even width `WIDTH` over several clock cycles. It gives a full-width signed product of `2*WIDTH` bits. A pulse on `start` while the unit is idle captures the multiplicand and the multiplier. The unit then retires two multiplier bits per cycle. Each cycle it inspects a three-bit overlapping slice of the multiplier and recodes it into a signed digit in {-2, -1, 0, +1, +2}. It adds the matching multiple of the multiplicand to a running partial product, then shifts that partial product two places arithmetically.

After `WIDTH/2` such steps the product register is updated and `done` is raised for one cycle. `busy` is high for every cycle in which steps are being taken. The product stays on its output until the next operation finishes. A caller waits for `busy` to be low, pulses `start` with the operands, and collects `product` when `done` appears.

Top module: `booth_mul_seq`

## Requirements
- R1: Each step recodes a 3-bit window w = {high, mid, low} as follows. Window 3'b000 and window 3'b111 both give digit 0. Windows 3'b001 and 3'b010 give +1. Window 3'b011 gives +2. Window 3'b100 gives -2. Windows 3'b101 and 3'b110 give -1. The step adds digit times the multiplicand to the partial product.
- R2: Step k (k = 0 .. WIDTH/2-1) uses multiplier bits 2k+1, 2k and 2k-1. The bit below bit 0 is taken as 0.
- R3: When `done` is high, `product` equals the signed product of the captured operands in 2*WIDTH bits. For example, 17 times -9 gives -153.
- R4: The boundary operands give exact results. The most negative value squared gives 2^(2*WIDTH-2). The most negative value times -1 gives +2^(WIDTH-1). Any product with a zero operand gives 0.
- R5: `start` is taken only while `busy` is low. A `start` raised while `busy` is high does not change the operands in flight, the result, or the number of results.
- R6: After an accepted `start`, `busy` is high for exactly WIDTH/2 consecutive cycles.
- R7: `done` is high for exactly one cycle, in the first cycle after `busy` falls.
- R8: `product` changes only in the cycle `done` is raised. Otherwise it holds its value.
- R9: The partial-product adder is WIDTH+2 bits wide. Adding the signed multiple of the multiplicand never overflows it, even for the most negative multiplicand with a ±2 digit.
- R10: After a synchronous active-low reset, `busy` and `done` are low and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiply; taken only while idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse: new product valid |
| product | output | 2*WIDTH | Signed product, held between operations |

## Verification
The hardest case to reach from the ports is a `start` that arrives while an operation is still in flight. If it were taken, it would silently corrupt the captured operands or cause an extra result. The stimulus raises `start` with different operands in the cycle right after an accepted request, so a leak shows up as a wrong product or as an unexpected `done`. The ±2 digits with the most negative multiplicand are the other tight spot. The operand sweep covers every multiplicand against multipliers whose bit pairs produce windows 3'b011 and 3'b100.

// File: rtl/mb_pkg.sv
// Shared types for the radix-4 Booth multiplier.
// Assumes: nothing beyond the standard language.
package mb_pkg;
    // Signed Booth digit decoded as controls for the addend path
    typedef struct packed {
        logic neg;   // subtract the selected multiple
        logic two;   // select 2*A instead of A
        logic zero;  // add nothing
    } digit_t;
endpackage

// File: rtl/mb_recoder.sv
// Booth recoder: maps a 3-bit overlapping multiplier window to a digit.
// Assumes: window is {upper, middle, lower bit}, lower is 0 for the first step.
module mb_recoder
    import mb_pkg::*;
(
    input  logic [2:0] window,
    output digit_t     digit
);
    // Decode window into sign, magnitude-2 and zero controls
    always_comb begin
        digit.zero = (window == 3'b000) || (window == 3'b111);
        digit.two  = (window == 3'b011) || (window == 3'b100);
        digit.neg  = window[2] && !digit.zero;
    end

    // R1: exactly one magnitude class applies per window
    always_comb begin
        a_digit_class_r1: assert ($countones({digit.zero, digit.two, window[1] ^ window[0]}) == 1);
    end
endmodule

// File: rtl/mb_datapath.sv
// Booth datapath: holds multiplicand, shifting multiplier and partial product.
// Assumes: WIDTH is even and >= 4; load and step are never high together.
module mb_datapath
    import mb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] prod_next
);
    localparam int AW = WIDTH + 2;

    logic [WIDTH-1:0] a_q;
    logic [AW-1:0]    acc_q;
    logic [WIDTH-1:0] x_q;
    logic             low_q;
    logic [AW-1:0]    mag;
    logic [AW-1:0]    addend;
    logic [AW-1:0]    sum;
    digit_t           dig;

    mb_recoder u_rec (
        .window ({x_q[1:0], low_q}),
        .digit  (dig)
    );

    // Select 0, A or 2A sign-extended, then invert with carry-in for negation
    always_comb begin
        if (dig.zero)
            mag = '0;
        else if (dig.two)
            mag = {a_q[WIDTH-1], a_q, 1'b0};
        else
            mag = {{2{a_q[WIDTH-1]}}, a_q};
        addend = dig.neg ? ~mag : mag;
        sum    = acc_q + addend + AW'(dig.neg);
    end

    // Product as it will stand after the current step's shift
    assign prod_next = {sum, x_q[WIDTH-1:2]};

    // Load operands, or add and shift two places arithmetically
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            acc_q <= '0;
            x_q   <= '0;
            low_q <= 1'b0;
        end else if (load) begin
            a_q   <= mcand;
            acc_q <= '0;
            x_q   <= mplier;
            low_q <= 1'b0;
        end else if (step) begin
            acc_q <= {{2{sum[AW-1]}}, sum[AW-1:2]};
            x_q   <= {sum[1:0], x_q[WIDTH-1:2]};
            low_q <= x_q[1];
        end
    end

    // R9: like-signed operands never yield an opposite-signed sum
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !dig.zero && (acc_q[AW-1] == addend[AW-1]) && (mag != '0))
            |-> (sum[AW-1] == acc_q[AW-1]));

    // R2: first step sees an implicit zero below bit 0
    p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (low_q == 1'b0));
endmodule

// File: rtl/mb_ctrl.sv
// Step sequencer: counts WIDTH/2 steps after an accepted start.
// Assumes: start is ignored whenever busy is high.
module mb_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int STEPS = WIDTH / 2;
    localparam int CW    = $clog2(STEPS) + 1;

    logic [CW-1:0] cnt_q;

    assign load = start && !busy;
    assign step = busy;
    assign last = busy && (cnt_q == '0);

    // Busy flag, remaining-step counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= last;
            if (load) begin
                busy  <= 1'b1;
                cnt_q <= CW'(STEPS - 1);
            end else if (last) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R6: an accepted start raises busy on the next cycle
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: done follows the fall of busy
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

// File: rtl/booth_mul_seq.sv
// Top: sequential radix-4 Booth signed multiplier with start/busy/done.
// Assumes: WIDTH even and >= 4; operands are two's complement.
module booth_mul_seq #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic               load;
    logic               step;
    logic               last;
    logic [2*WIDTH-1:0] prod_next;

    mb_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    mb_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand     (mcand),
        .mplier    (mplier),
        .prod_next (prod_next)
    );

    // Capture the finished product on the final step
    always_ff @(posedge clk) begin
        if (!rst_n)
            product <= '0;
        else if (last)
            product <= prod_next;
    end

    // R8: product holds whenever no completion is signalled
    p_prod_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));
endmodule

// File: tb/sim_booth_mul_seq.sv
// Scoreboard bench: driver queues expected products, monitor compares on done.
module sim_booth_mul_seq;
    localparam int W      = 8;
    localparam int PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [2*W-1:0] expq [$];
    int  bcnt = 0;
    bit  prev_done = 1'b0;
    bit  stable_bad = 1'b0;
    logic [2*W-1:0] last_prod = '0;

    always #(PERIOD/2) clk = ~clk;

    booth_mul_seq #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
        .mplier(mplier), .busy(busy), .done(done), .product(product)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] x);
        logic [2*W-1:0] ea, ex;
        ea = {{W{a[W-1]}}, a};
        ex = {{W{x[W-1]}}, x};
        return ea * ex;
    endfunction

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: wait for idle, pulse start, push the expected result (R1 R2 R3)
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] x);
        @(negedge clk);
        while (busy) @(negedge clk);
        mcand  = a;
        mplier = x;
        start  = 1'b1;
        expq.push_back(ref_mul(a, x));
        @(negedge clk);
        start = 1'b0;
    endtask

    // R5: a second start right after acceptance must be dropped
    task automatic run_with_intrusion(input logic [W-1:0] a, input logic [W-1:0] x);
        run(a, x);
        mcand  = ~a;
        mplier = x + 8'd3;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compare on done, check busy length, pulse width, holding
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) bcnt++;
            if (!done && product != last_prod) stable_bad = 1'b1;
            if (done) begin
                check(!prev_done, "R7 done pulse width", {15'd0, prev_done}, '0);
                check(bcnt == W/2, "R6 busy cycles", 2*W'(bcnt), 2*W'(W/2));
                check(!stable_bad, "R8 product held", product, last_prod);
                if (expq.size() == 0) begin
                    check(1'b0, "R5 unexpected result", product, '0);
                end else begin
                    logic [2*W-1:0] e;
                    e = expq.pop_front();
                    check(product == e, "R3 product", product, e);
                end
                bcnt = 0;
                stable_bad = 1'b0;
                last_prod = product;
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && product == '0, "R10 reset state", product, '0);
        rst_n = 1'b1;
        // R3: worked example
        run(8'd17, -8'sd9);
        // R4: boundary operands
        run(8'h80, 8'h80);
        run(8'h80, 8'hFF);
        run(8'hFF, 8'h80);
        run(8'h00, 8'h80);
        run(8'h7F, 8'h00);
        run(8'h7F, 8'h7F);
        // R2: multiplier 1 only fires through the implicit low zero
        run(8'h55, 8'h01);
        // R5: intrusion during busy
        run_with_intrusion(8'd23, 8'd5);
        run_with_intrusion(8'h80, 8'h66);
        // R1: all multiplicands against multipliers covering every window
        for (int a = 0; a < 256; a++) begin
            foreach (sweep_x[i]) run(8'(a), sweep_x[i]);
        end
        @(negedge clk);
        while (busy || expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R5 queue drained", 2*W'(expq.size()), '0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    logic [W-1:0] sweep_x [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h33,
                                   8'hCC, 8'h80, 8'h7F, 8'hFF, 8'hA5, 8'h5A};

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule